// File: doc/BRIEF.md
# Multi-locality ownership arbiter

This block decides which of five prioritized localities owns a shared command interface at any moment. A bus access carries a locality number in address bits [14:12]. Each locality has an 8-bit access register. Software writes it to request ownership, give ownership back, force ownership away from a lower-priority owner (seize), or acknowledge that ownership was taken from it. The arbiter applies those writes and computes the value a read of that register returns. It exports the current owner number so the command data path can refuse accesses from localities that do not own the interface.

When ownership must move while a command is executing, the arbiter does not switch at once. It raises a one-cycle cancel request toward the command engine and holds the current owner until the engine reports that the response has arrived. With no command running, the switch happens at the same clock edge as the write. Every switch to a real locality raises a one-cycle locality-changed interrupt request that carries the new owner's number.

Access register layout, as written and as read: bit 0 request-use, bit 1 pending-request (read only), bit 2 seize (write only, always reads 0), bit 3 been-seized, bit 4 active-locality, bit 7 register-valid (read only). Bits 5 and 6 are unused and read 0. The owner output is 0xFF when no locality owns the interface.

Top module: `loc_arbiter`

## Requirements
- R1: After reset no locality owns the interface (owner = 0xFF), all flags are clear, and a read of any locality 0..4 returns 0x80.
- R2: A request-use write (bit 0) with no owner grants ownership to the writer at that edge. With a different owner, it only sets the writer's request-use flag. From the owner, it has no effect.
- R3: An active-locality write (bit 4) from the owner releases the interface to the highest-numbered locality whose request-use flag is set, or to no owner (0xFF) if none is set. The same write from a non-owner clears the writer's request-use flag.
- R4: A seize write (bit 2) is granted only when there is no owner or the writer's number is above the owner's, and only when neither the writer nor any higher locality already has a seize pending. Otherwise it is ignored.
- R5: On any handoff, the old owner loses active-locality. It also loses request-use unless the handoff is a seize, in which case it gains been-seized instead. The new owner gets active-locality, and its request-use and seize flags are cleared. A granted seize clears the pending seizes of all lower localities.
- R6: The read value has bit 7 set, bit 4 set for the owner, bit 3 showing been-seized, bit 0 showing request-use, and bit 1 set when any other locality has request-use set. Bit 2 always reads 0.
- R7: Writing 1 to bit 3 clears the writer's been-seized flag. A write with bit 2 set has its bits 0 and 4 ignored.
- R8: A handoff started while cmd_busy is high raises cancel_req for exactly one cycle and keeps the old owner until resp_done. The handoff then completes at that edge. With cmd_busy low, it completes at the edge of the write. resp_done has no effect when no handoff is waiting.
- R9: Every handoff to a locality 0..4 raises chg_irq for the one cycle after the edge, with chg_loc equal to the new owner. A release to no owner raises nothing.
- R10: While a handoff waits, only been-seized clears and seize writes are applied. A granted seize retargets the waiting handoff to the writer without a second cancel. Request-use and active-locality writes are ignored.
- R11: Writes addressed to localities 5..7 are ignored, and reads there return 0xFF.
- R12: The owner output is always 0xFF or a locality number below five, and changes only at a handoff.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_wr | input | 1 | Write strobe for the access register |
| acc_addr | input | 15 | Access address; bits [14:12] select the locality for read and write |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read value of the addressed locality's access register (combinational) |
| cmd_busy | input | 1 | A command is currently executing |
| resp_done | input | 1 | The response to a cancelled command has arrived |
| cancel_req | output | 1 | One-cycle request to cancel the executing command |
| owner | output | 8 | Current owner locality, 0xFF for none |
| chg_irq | output | 1 | One-cycle locality-changed interrupt request |
| chg_loc | output | 3 | Locality that the interrupt request is for |

## Verification
All flag, owner, cancel and interrupt results are registered at the clock edge that samples the write. The bench drives every write on a falling edge and checks owner, chg_irq and cancel_req on the next falling edge, the only half-cycle in which the one-cycle pulses are high. The read value is combinational from the registered state, so the bench changes acc_addr and checks acc_rdata one time step later, with no clock edge in between. For a waiting handoff, the owner is checked once after the cancel and again after a later seize retarget. It is checked finally at the falling edge after the resp_done edge, where the handoff is due.

// File: rtl/loc_arb_pkg.sv
// Package: shared constants for the locality ownership arbiter.
// Assumes an 8-bit access register and at most eight encodable localities.
package loc_arb_pkg;
    localparam int NUM_LOC   = 5;
    localparam int LOC_W     = 3;
    localparam int OWN_W     = 8;
    localparam int ADDR_W    = 15;
    localparam int LOC_LSB   = 12;
    localparam int DATA_W    = 8;
    localparam logic [OWN_W-1:0] OWN_NONE = 8'hFF;

    // Bit positions inside the access register
    localparam int B_REQ   = 0;
    localparam int B_PEND  = 1;
    localparam int B_SEIZE = 2;
    localparam int B_BS    = 3;
    localparam int B_ACT   = 4;
    localparam int B_VALID = 7;
endpackage

// File: rtl/loc_flag_bank.sv
// Flag bank: one set of request-use, seize and been-seized flags per locality.
// Assumes set and clear vectors from one decision source; set wins over clear.
module loc_flag_bank #(
    parameter int NLOC = loc_arb_pkg::NUM_LOC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLOC-1:0] set_req,
    input  logic [NLOC-1:0] clr_req,
    input  logic [NLOC-1:0] set_sz,
    input  logic [NLOC-1:0] clr_sz,
    input  logic [NLOC-1:0] set_bs,
    input  logic [NLOC-1:0] clr_bs,
    output logic [NLOC-1:0] req,
    output logic [NLOC-1:0] sz,
    output logic [NLOC-1:0] bs
);
    for (genvar i = 0; i < NLOC; i++) begin : g_loc
        // Update the three flags of locality i
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req[i] <= 1'b0;
                sz[i]  <= 1'b0;
                bs[i]  <= 1'b0;
            end else begin
                req[i] <= (req[i] & ~clr_req[i]) | set_req[i];
                sz[i]  <= (sz[i]  & ~clr_sz[i])  | set_sz[i];
                bs[i]  <= (bs[i]  & ~clr_bs[i])  | set_bs[i];
            end
        end
    end
endmodule

// File: rtl/loc_abort_ctl.sv
// Abort handshake: defers a handoff while a command runs, issues one cancel
// pulse and fires the handoff when the response arrives.
// Assumes start is only raised while no handoff is waiting.
module loc_abort_ctl #(
    parameter int LOC_W = loc_arb_pkg::LOC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LOC_W-1:0] start_loc,
    input  logic             retarget,
    input  logic [LOC_W-1:0] retarget_loc,
    input  logic             cmd_busy,
    input  logic             resp_done,
    output logic             waiting,
    output logic             fire,
    output logic [LOC_W-1:0] fire_loc,
    output logic             cancel_req
);
    logic [LOC_W-1:0] next_q;

    // Track the waiting handoff and its target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting    <= 1'b0;
            next_q     <= '0;
            cancel_req <= 1'b0;
        end else begin
            cancel_req <= 1'b0;
            if (start && cmd_busy) begin
                waiting    <= 1'b1;
                next_q     <= start_loc;
                cancel_req <= 1'b1;
            end else if (waiting && resp_done) begin
                waiting <= 1'b0;
            end else if (waiting && retarget) begin
                next_q <= retarget_loc;
            end
        end
    end

    // Handoff fires at once when idle, or on the response while waiting
    always_comb begin
        fire     = (start && !cmd_busy) || (waiting && resp_done);
        fire_loc = waiting ? next_q : start_loc;
    end
endmodule

// File: rtl/loc_arbiter.sv
// Top: decodes access-register writes per locality, decides grants, releases
// and seizes, and drives the owner, interrupt and read value.
// Assumes one access per cycle and a read value taken combinationally.
module loc_arbiter #(
    parameter int NLOC    = loc_arb_pkg::NUM_LOC,
    parameter int LOC_W   = loc_arb_pkg::LOC_W,
    parameter int OWN_W   = loc_arb_pkg::OWN_W,
    parameter int ADDR_W  = loc_arb_pkg::ADDR_W,
    parameter int LOC_LSB = loc_arb_pkg::LOC_LSB,
    parameter int DATA_W  = loc_arb_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              cmd_busy,
    input  logic              resp_done,
    output logic              cancel_req,
    output logic [OWN_W-1:0]  owner,
    output logic              chg_irq,
    output logic [LOC_W-1:0]  chg_loc
);
    import loc_arb_pkg::*;

    logic [NLOC-1:0]  req, sz, bs;
    logic [NLOC-1:0]  set_req, clr_req, set_sz, clr_sz, set_bs, clr_bs;
    logic [LOC_W-1:0] wl, own_l, hi_loc, start_loc, fire_loc, direct_loc, hand_loc;
    logic             wl_ok, own_vld, proc, hi_found, sz_above, seize_ok;
    logic             wd_req, wd_act, wd_sz, wd_bs;
    logic             start, fire, abort_wait, retarget;
    logic             direct, direct_vld, hand, hand_vld, is_sz;

    assign wl      = acc_addr[LOC_LSB +: LOC_W];
    assign wl_ok   = (32'(wl) < NLOC);
    assign own_vld = (owner != OWN_NONE);
    assign own_l   = owner[LOC_W-1:0];

    loc_flag_bank #(.NLOC(NLOC)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_req(set_req), .clr_req(clr_req),
        .set_sz(set_sz), .clr_sz(clr_sz),
        .set_bs(set_bs), .clr_bs(clr_bs),
        .req(req), .sz(sz), .bs(bs)
    );

    loc_abort_ctl #(.LOC_W(LOC_W)) u_abort (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_loc(start_loc),
        .retarget(retarget), .retarget_loc(wl),
        .cmd_busy(cmd_busy), .resp_done(resp_done),
        .waiting(abort_wait), .fire(fire), .fire_loc(fire_loc),
        .cancel_req(cancel_req)
    );

    // Decode the write and find the highest requester and higher seizes
    always_comb begin
        proc     = acc_wr && wl_ok && !(abort_wait && resp_done);
        wd_sz    = acc_wdata[B_SEIZE];
        wd_req   = acc_wdata[B_REQ] && !wd_sz;
        wd_act   = acc_wdata[B_ACT] && !wd_sz;
        wd_bs    = acc_wdata[B_BS];
        hi_found = 1'b0;
        hi_loc   = '0;
        sz_above = 1'b0;
        for (int c = 0; c < NLOC; c++) begin
            if (req[c]) begin
                hi_found = 1'b1;
                hi_loc   = LOC_W'(c);
            end
            if (sz[c] && (LOC_W'(c) > wl)) sz_above = 1'b1;
        end
        seize_ok = proc && wd_sz && (!own_vld || (wl > own_l)) &&
                   !sz[wl] && !sz_above;
    end

    // Decide flag changes, handoff start, retarget and direct grant
    always_comb begin
        set_req = '0; clr_req = '0; set_sz = '0;
        clr_sz  = '0; set_bs  = '0; clr_bs = '0;
        start = 1'b0; start_loc = '0; retarget = 1'b0;
        direct = 1'b0; direct_vld = 1'b0; direct_loc = '0;
        if (proc) begin
            if (wd_bs) clr_bs[wl] = 1'b1;
            if (seize_ok) begin
                for (int c = 0; c < NLOC; c++)
                    if (LOC_W'(c) < wl) clr_sz[c] = 1'b1;
            end
            if (!abort_wait) begin
                if (wd_act) begin
                    if (own_vld && own_l == wl) begin
                        if (hi_found) begin
                            start = 1'b1; start_loc = hi_loc;
                        end else begin
                            direct = 1'b1;
                        end
                    end else begin
                        clr_req[wl] = 1'b1;
                    end
                end
                if (wd_req && !(own_vld && own_l == wl)) begin
                    if (own_vld) set_req[wl] = 1'b1;
                    else begin
                        direct = 1'b1; direct_vld = 1'b1; direct_loc = wl;
                    end
                end
                if (seize_ok) begin
                    if (cmd_busy) set_sz[wl] = 1'b1;
                    start = 1'b1; start_loc = wl;
                end
            end else if (seize_ok) begin
                set_sz[wl] = 1'b1;
                retarget   = 1'b1;
            end
        end
        hand     = fire || direct;
        hand_vld = fire || direct_vld;
        hand_loc = fire ? fire_loc : direct_loc;
        is_sz    = abort_wait ? sz[fire_loc] : (seize_ok && fire);
        if (hand) begin
            if (own_vld) begin
                if (is_sz) set_bs[own_l] = 1'b1;
                else       clr_req[own_l] = 1'b1;
            end
            if (hand_vld) begin
                clr_req[hand_loc] = 1'b1;
                clr_sz[hand_loc]  = 1'b1;
            end
        end
    end

    // Register the owner and the locality-changed request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner   <= OWN_NONE;
            chg_irq <= 1'b0;
            chg_loc <= '0;
        end else begin
            chg_irq <= hand && hand_vld;
            chg_loc <= hand_loc;
            if (hand) owner <= hand_vld ? OWN_W'(hand_loc) : OWN_NONE;
        end
    end

    // Build the read value of the addressed locality
    always_comb begin
        acc_rdata = '1;
        if (wl_ok) begin
            acc_rdata          = '0;
            acc_rdata[B_VALID] = 1'b1;
            acc_rdata[B_ACT]   = own_vld && (own_l == wl);
            acc_rdata[B_BS]    = bs[wl];
            acc_rdata[B_REQ]   = req[wl];
            for (int c = 0; c < NLOC; c++)
                if (req[c] && (LOC_W'(c) != wl)) acc_rdata[B_PEND] = 1'b1;
        end
    end
endmodule

// File: rtl/loc_arbiter_chk.sv
// Checker: timing properties of owner, cancel and interrupt outputs.
// Assumes binding into loc_arbiter with the waiting flag brought out.
module loc_arbiter_chk #(
    parameter int NLOC  = loc_arb_pkg::NUM_LOC,
    parameter int LOC_W = loc_arb_pkg::LOC_W,
    parameter int OWN_W = loc_arb_pkg::OWN_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OWN_W-1:0] owner,
    input logic             chg_irq,
    input logic [LOC_W-1:0] chg_loc,
    input logic             cancel_req,
    input logic             waiting,
    input logic             resp_done
);
    localparam logic [OWN_W-1:0] NONE = loc_arb_pkg::OWN_NONE;

    a_r8_cancel_single: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_req |=> !cancel_req);

    a_r8_hold_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !resp_done) |=> $stable(owner));

    a_r9_irq_matches_owner: assert property (@(posedge clk) disable iff (!rst_n)
        chg_irq |-> (owner != NONE && owner[LOC_W-1:0] == chg_loc));

    a_r9_change_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (owner != $past(owner) && owner != NONE) |-> chg_irq);

    a_r12_owner_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == NONE) || (32'(owner) < NLOC));
endmodule

bind loc_arbiter loc_arbiter_chk #(.NLOC(NLOC), .LOC_W(LOC_W), .OWN_W(OWN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .owner(owner), .chg_irq(chg_irq),
    .chg_loc(chg_loc), .cancel_req(cancel_req), .waiting(abort_wait),
    .resp_done(resp_done)
);

// File: tb/loc_arbiter_bench.sv
module loc_arbiter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_wr = 1'b0;
    logic [14:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic        cmd_busy = 1'b0;
    logic        resp_done = 1'b0;
    logic        cancel_req;
    logic [7:0]  owner;
    logic        chg_irq;
    logic [2:0]  chg_loc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    loc_arbiter u_loc_arbiter (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .cmd_busy(cmd_busy),
        .resp_done(resp_done), .cancel_req(cancel_req), .owner(owner),
        .chg_irq(chg_irq), .chg_loc(chg_loc)
    );

    typedef struct packed {
        logic [2:0] wloc;
        logic [7:0] wdata;
        logic [2:0] rloc;
        logic [7:0] exp_rd;
        logic [7:0] exp_own;
        logic       exp_irq;
    } vec_t;

    // Bits: 0 req, 1 pending, 2 seize, 3 been-seized, 4 active, 7 valid
    localparam vec_t TBL [0:13] = '{
        '{3'd2, 8'h01, 3'd2, 8'h90, 8'h02, 1'b1}, // R2 grant with no owner
        '{3'd0, 8'h01, 3'd0, 8'h81, 8'h02, 1'b0}, // R2 request sets flag
        '{3'd3, 8'h01, 3'd2, 8'h92, 8'h02, 1'b0}, // R6 pending seen by owner
        '{3'd1, 8'h10, 3'd1, 8'h82, 8'h02, 1'b0}, // R3 non-owner release
        '{3'd0, 8'h10, 3'd0, 8'h82, 8'h02, 1'b0}, // R3 non-owner clears own req
        '{3'd2, 8'h10, 3'd2, 8'h80, 8'h03, 1'b1}, // R3 release to highest requester
        '{3'd4, 8'h15, 3'd3, 8'h88, 8'h04, 1'b1}, // R4 R5 R7 seize, strip, been-seized
        '{3'd3, 8'h08, 3'd3, 8'h80, 8'h04, 1'b0}, // R7 clear been-seized
        '{3'd2, 8'h04, 3'd2, 8'h80, 8'h04, 1'b0}, // R4 lower seize ignored
        '{3'd4, 8'h10, 3'd4, 8'h80, 8'hFF, 1'b0}, // R3 R9 release to nobody
        '{3'd1, 8'h04, 3'd1, 8'h90, 8'h01, 1'b1}, // R4 seize with no owner
        '{3'd5, 8'h01, 3'd1, 8'h90, 8'h01, 1'b0}, // R11 locality 5 write ignored
        '{3'd1, 8'h01, 3'd1, 8'h90, 8'h01, 1'b0}, // R2 owner request no effect
        '{3'd0, 8'h01, 3'd1, 8'h92, 8'h01, 1'b0}  // R2 request behind owner
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one write at a falling edge; returns at the next falling edge
    task automatic wr(input logic [2:0] loc, input logic [7:0] data);
        acc_wr = 1'b1; acc_addr = {loc, 12'h000}; acc_wdata = data;
        @(negedge clk);
        acc_wr = 1'b0; acc_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] loc, input logic [7:0] exp);
        acc_addr = {loc, 12'h004};
        #1;
        chk(tag, acc_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 owner after reset", owner, 8'hFF);
        chk("R1 irq after reset", {7'd0, chg_irq}, 8'h00);
        rd_chk("R1 read loc0 after reset", 3'd0, 8'h80);
        rd_chk("R1 read loc4 after reset", 3'd4, 8'h80);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 14; i++) begin
            wr(TBL[i].wloc, TBL[i].wdata);
            chk($sformatf("R12 row %0d owner", i), owner, TBL[i].exp_own);
            chk($sformatf("R9 row %0d irq", i), {7'd0, chg_irq}, {7'd0, TBL[i].exp_irq});
            if (TBL[i].exp_irq)
                chk($sformatf("R9 row %0d irq locality", i), {5'd0, chg_loc}, TBL[i].exp_own);
            rd_chk($sformatf("R6 row %0d read", i), TBL[i].rloc, TBL[i].exp_rd);
        end

        // R11 read of an unused locality
        rd_chk("R11 read loc5", 3'd5, 8'hFF);
        rd_chk("R11 read loc7", 3'd7, 8'hFF);

        // R8 handoff deferred while a command runs (owner 1, req0 set)
        cmd_busy = 1'b1;
        wr(3'd1, 8'h10);
        chk("R8 cancel raised", {7'd0, cancel_req}, 8'h01);
        chk("R8 owner held", owner, 8'h01);
        chk("R9 no irq while waiting", {7'd0, chg_irq}, 8'h00);
        // R10 seize retargets without a second cancel
        wr(3'd3, 8'h04);
        chk("R10 no second cancel", {7'd0, cancel_req}, 8'h00);
        chk("R8 owner still held", owner, 8'h01);
        wr(3'd2, 8'h04);                 // R4 ignored: higher seize pending
        wr(3'd3, 8'h04);                 // R4 ignored: own seize pending
        wr(3'd4, 8'h01);                 // R10 request ignored while waiting
        chk("R8 owner held before response", owner, 8'h01);
        resp_done = 1'b1;
        @(negedge clk);
        resp_done = 1'b0;
        chk("R8 handoff at response", owner, 8'h03);
        chk("R9 irq at response", {7'd0, chg_irq}, 8'h01);
        chk("R9 irq locality at response", {5'd0, chg_loc}, 8'h03);
        rd_chk("R5 seized owner flags", 3'd1, 8'h8A);
        rd_chk("R10 request write had no effect", 3'd4, 8'h82);
        rd_chk("R5 new owner flags", 3'd3, 8'h92);

        // R8 response with nothing waiting has no effect
        cmd_busy = 1'b0;
        resp_done = 1'b1;
        @(negedge clk);
        resp_done = 1'b0;
        chk("R8 stray response", owner, 8'h03);
        chk("R9 stray response irq", {7'd0, chg_irq}, 8'h00);

        // R3 release with busy low completes at once to requester 0
        wr(3'd3, 8'h10);
        chk("R3 immediate release", owner, 8'h00);
        chk("R8 no cancel when idle", {7'd0, cancel_req}, 8'h00);
        rd_chk("R5 released owner flags", 3'd3, 8'h80);

        // R1 reset in mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 owner after second reset", owner, 8'hFF);
        rd_chk("R1 flags cleared by reset", 3'd1, 8'h80);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule